// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of a parameterised width and returns the full double-width signed product. It runs one multiplier bit per clock. Before the scan begins, a zero bit is placed to the right of the multiplier. Each step then looks at the current multiplier bit together with the bit to its right. From that pair it adds the multiplicand, subtracts it, or leaves the running sum alone, always at the weight of the current bit.

Because of this recoding, negative operands need no magnitude conversion and no sign fix-up afterwards. A run of ones in the multiplier costs one subtract at its low end and one add above its high end.

A client pulses the start input with both operands present while the block is idle. The busy output stays high for one cycle per operand bit. Done then pulses for one cycle, and the product output holds its value until the next accepted start. A start seen while the block is busy has no effect.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is asserted, and after it is released, busy and done read 0 and the product output reads all zeros until the first accepted start.
- R2: A start sampled high while busy is low is accepted, and busy reads 1 after the next rising clock edge.
- R3: After an accepted start, busy stays high for exactly WIDTH clock cycles.
- R4: Done is high for exactly one cycle, on the cycle in which busy has just dropped from 1 to 0.
- R5: When done is high, the product output equals the signed product of the multiplicand and the multiplier sampled with the accepted start, as a 2*WIDTH-bit two's-complement value. The output then holds that value unchanged until the next accepted start.
- R6: A start that arrives while busy is high is ignored, as are operand changes during a run. The run in progress completes with its original operands and its original timing.
- R7: The most negative operand value (only the top bit set) gives a correct product in either operand position, including when both operands take it, where the result is +2^(2*WIDTH-2).
- R8: The recoding gives correct signed results in all of these cases: a multiplier of 0 (result 0), a multiplier of all ones, i.e. -1 (result is the negated multiplicand), and multipliers that mix runs of ones and zeros, for example 3, -3 and 30 against multiplicands 7, -7 and 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| start_i | input | 1 | Request to begin a multiplication; taken only when idle |
| mcand_i | input | WIDTH | Signed multiplicand, sampled at an accepted start |
| mplier_i | input | WIDTH | Signed multiplier, sampled at an accepted start |
| busy_o | output | 1 | High while the multiplication is in progress |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | 2*WIDTH | Signed product, valid from done until the next accepted start |

## Verification
A wrong step decision or a bad shift corrupts the shared accumulator-multiplier register. That error becomes visible only when done rises, WIDTH cycles after the start, as a wrong product word. The vectors therefore include signs in every combination, runs of ones, and the most negative value, so that each recoding outcome and the guard bit each touch at least one result. A fault in the step counter shows at once, in the length of the busy window and in the position of the done pulse. A latched operand that is overwritten mid-run shows in the final product of the run that a stray start was aimed at.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Action chosen for one scan step from a multiplier bit pair
  typedef enum logic [1:0] {
    STEP_SKIP = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic  cur_bit_i,
  input  logic  prev_bit_i,
  output step_e step_o
);

  always_comb begin
    unique case ({cur_bit_i, prev_bit_i})
      2'b01:   step_o = STEP_ADD;   // end of a run of ones
      2'b10:   step_o = STEP_SUB;   // start of a run of ones
      default: step_o = STEP_SKIP;  // inside a run or inside zeros
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 33
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] addend_i,
  input  step_e        step_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] operand;
  logic         carry_in;

  always_comb begin
    operand  = '0;
    carry_in = 1'b0;
    unique case (step_i)
      STEP_ADD: begin
        operand  = addend_i;
        carry_in = 1'b0;
      end
      STEP_SUB: begin
        operand  = ~addend_i;
        carry_in = 1'b1;
      end
      default: begin
        operand  = '0;
        carry_in = 1'b0;
      end
    endcase
    sum_o = acc_i + operand + W'(carry_in);
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_en_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      PH_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign load_o    = (phase_q == PH_IDLE) && start_i;
  assign step_en_o = (phase_q == PH_RUN);
  assign busy_o    = (phase_q == PH_RUN);
  assign done_o    = done_q;

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);

  // Accumulator carries one guard bit so the most negative multiplicand
  // can be added or subtracted without losing its sign.
  localparam int AW = WIDTH + 1;

  logic             rst_sync_n;
  logic             load, step_en, reg_en;
  step_e            step;

  logic [AW-1:0]    acc_q, acc_d;
  logic [WIDTH-1:0] mq_q, mq_d;
  logic             prev_q, prev_d;
  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [AW-1:0]    mcand_ext;
  logic [AW-1:0]    sum;

  booth_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  booth_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .load_o    (load),
    .step_en_o (step_en),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  booth_recode u_recode (
    .cur_bit_i  (mq_q[0]),
    .prev_bit_i (prev_q),
    .step_o     (step)
  );

  assign mcand_ext = {mcand_q[WIDTH-1], mcand_q};

  booth_addsub #(.W(AW)) u_addsub (
    .acc_i    (acc_q),
    .addend_i (mcand_ext),
    .step_i   (step),
    .sum_o    (sum)
  );

  // Next-state: load fresh operands, or add/sub then arithmetic shift right
  always_comb begin
    acc_d   = acc_q;
    mq_d    = mq_q;
    prev_d  = prev_q;
    mcand_d = mcand_q;
    if (load) begin
      acc_d   = '0;
      mq_d    = mplier_i;
      prev_d  = 1'b0;
      mcand_d = mcand_i;
    end else if (step_en) begin
      acc_d  = {sum[AW-1], sum[AW-1:1]};
      mq_d   = {sum[0], mq_q[WIDTH-1:1]};
      prev_d = mq_q[0];
    end
  end

  assign reg_en = load | step_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q  <= '0;
      mq_q   <= '0;
      prev_q <= 1'b0;
    end else if (reg_en) begin
      acc_q  <= acc_d;
      mq_q   <= mq_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mcand_q <= '0;
    else if (load)    mcand_q <= mcand_d;
  end

  assign product_o = {acc_q[WIDTH-1:0], mq_q};

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic [WIDTH-1:0]   mcand_q
);

  localparam int LW = $clog2(WIDTH + 2) + 1;

  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  run_len <= '0;
    else if (busy_o)  run_len <= run_len + LW'(1);
    else              run_len <= '0;
  end

  // R1: outputs quiet while reset is held
  always_ff @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_quiet_R1: assert (!busy_o && !done_o)
        else $error("busy/done high during reset");
    end
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy_o) |-> (run_len == LW'(WIDTH)));

  assert_done_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> ($past(busy_o) && !busy_o));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  assert_product_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$past(busy_o) && !busy_o) |-> $stable(product_o));

  assert_operand_kept_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(busy_o) && busy_o) |-> $stable(mcand_q));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .product_o  (product_o),
  .mcand_q    (mcand_q)
);

// File: tb/test_booth_seq_mul.sv
module test_booth_seq_mul;

  localparam int W  = 32;
  localparam int NV = 14;

  // {multiplicand, multiplier, expected product}
  localparam logic [4*W-1:0] VEC [NV] = '{
    {32'd7,          32'd3,          64'd21},                     // R8
    {32'd7,          32'hFFFF_FFFD,  64'hFFFF_FFFF_FFFF_FFEB},    // R8
    {32'hFFFF_FFF9,  32'd3,          64'hFFFF_FFFF_FFFF_FFEB},    // R8
    {32'hFFFF_FFF9,  32'hFFFF_FFFD,  64'd21},                     // R8
    {32'd20,         32'd30,         64'd600},                    // R8
    {32'h8000_0000,  32'd0,          64'd0},                      // R8
    {32'd12345,      32'hFFFF_FFFF,  64'hFFFF_FFFF_FFFF_CFC7},    // R8
    {32'h8000_0000,  32'h8000_0000,  64'h4000_0000_0000_0000},    // R7
    {32'h8000_0000,  32'd1,          64'hFFFF_FFFF_8000_0000},    // R7
    {32'h8000_0000,  32'hFFFF_FFFF,  64'h0000_0000_8000_0000},    // R7
    {32'h7FFF_FFFF,  32'h8000_0000,  64'hC000_0000_8000_0000},    // R7
    {32'h7FFF_FFFF,  32'h7FFF_FFFF,  64'h3FFF_FFFF_0000_0001},    // R5
    {32'hFFFF_FFFF,  32'hFFFF_FFFF,  64'd1},                      // R5
    {32'h5555_5555,  32'd2,          64'h0000_0000_AAAA_AAAA}     // R5
  };

  logic               clk;
  logic               rst_n;
  logic               start_i;
  logic [W-1:0]       mcand_i;
  logic [W-1:0]       mplier_i;
  logic               busy_o;
  logic               done_o;
  logic [2*W-1:0]     product_o;

  int checks;
  int failures;
  int cycles;

  booth_seq_mul #(.WIDTH(W)) i_booth_seq_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Launch one multiplication and wait for done; optional stray starts mid-run
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2*W-1:0] exp, input bit stray);
    int busy_cnt;
    int guard;
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk);
    start_i  = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    busy_cnt = 0;
    guard    = 0;
    while (!done_o && guard < 4 * W) begin
      if (busy_o) busy_cnt++;
      if (stray && busy_cnt == 5) begin
        start_i  = 1'b1;
        mcand_i  = 32'h1234_5678;
        mplier_i = 32'h0BAD_F00D;
      end
      if (stray && busy_cnt == 9) start_i = 1'b0;
      guard++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(busy_cnt == W, "R3 busy length", 64'(busy_cnt), 64'(W));
    check(done_o && !busy_o, "R4 done with busy low", {62'd0, done_o, busy_o}, 64'd2);
    check(product_o == exp, stray ? "R6 stray start ignored" : "R5/R7/R8 product",
          product_o, exp);
    @(negedge clk);
    check(!done_o, "R4 done one cycle", 64'(done_o), 64'd0);
    check(product_o == exp, "R5 product held", product_o, exp);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    cycles   = 0;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o, "R1 reset outputs", {62'd0, busy_o, done_o}, 64'd0);
    check(product_o == '0, "R1 reset product", product_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && product_o == '0, "R1 after release", product_o, 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_mul(VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W], VEC[i][2*W-1:0], 1'b0);
    end

    // R6: stray start and operand changes mid-run
    run_mul(32'hFFFF_FFF9, 32'd30, 64'hFFFF_FFFF_FFFF_FF2E, 1'b1);

    // R5: idle product holds for several cycles with operands moving
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mcand_i  = 32'(k * 77);
      mplier_i = 32'(k * 13);
      check(product_o == 64'hFFFF_FFFF_FFFF_FF2E, "R5 idle hold", product_o,
            64'hFFFF_FFFF_FFFF_FF2E);
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = 32'd99;
    mplier_i = 32'd99;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && product_o == '0, "R1 mid-run reset", product_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Run after reset recovers
    run_mul(32'd20, 32'd30, 64'd600, 1'b0);

    finish_run();
  end

endmodule